// File: doc/BRIEF.md
# Burst-Four SRAM Core with Coherent Write Buffer

This block is a synchronous static memory core with independent read and write ports. Every access moves a burst of four data words that share one burst address. Commands are sampled on the rising edge of the base clock. Data travels at twice the command rate: each base cycle carries two beats. In this model the two beats of a cycle appear side by side on an "a" lane (the beat of the rising edge) and a "b" lane (the beat of the falling edge). Each data word is 18 bits, made of two 9-bit bytes. Byte 0 occupies bits [8:0] and byte 1 occupies bits [17:9].

A write is not stored in the array straight away. A completed write burst enters a two-entry buffer. It is committed to the array only when a later write burst completes and pushes it out. That happens on the third write counted from the command that wrote it. A read that targets an address still held in the buffer is served from the buffer. The merge is done per byte, so the data returned is always the latest that was written.

Top module: `sram_b4_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_valid` is 0. Reset is synchronous and active high.
- R2: A write command is `wr_n` low at rising edge t, with `wr_addr` giving the burst address. Beats 0 and 1 are taken on `wd_a`/`wd_b` at edge t+1. Beats 2 and 3 are taken on `wd_a`/`wd_b` at edge t+2. A later read of that address returns all four beats in order.
- R3: A read command is `rd_n` low at edge t. `rd_valid` is then high in the two cycles after t. The first cycle carries beat 0 on `rq_a` and beat 1 on `rq_b`. The second cycle carries beat 2 on `rq_a` and beat 3 on `rq_b`. Each beat is on the same lane it used when it was written.
- R4: Each beat has active-low byte enables. For beats 0 and 2 they are `bw_a_n`; for beats 1 and 3 they are `bw_b_n`. Bit j controls byte j. A low enable stores that byte and a high enable keeps the old byte.
- R5: A beat whose byte enables are all high is aborted, and its whole stored word is kept.
- R6: While `wr_n` is high and no write is in progress, the values on the data and enable lanes change nothing.
- R7: A command that arrives in the second cycle of the same port's operation (edge t+1) is ignored. A command at edge t+2 is accepted.
- R8: A read of an address held in the buffer returns, for each byte, the value from the newest entry that enabled that byte. Otherwise it takes the older entry, and otherwise the array.
- R9: A buffered write reaches the array only when a later write burst completes while the buffer already holds two entries. The array is then updated in write order.
- R10: A read sees a write only if the write's last beats were sampled at an edge before the read command. A read at the same edge as those last beats returns the earlier data.
- R11: A read and a write may be issued at the same edge and proceed independently.
- R12: Reset clears the buffer. Writes not yet committed are lost, and later reads of those addresses return the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Write command, active low |
| wr_addr | input | AW | Write burst address |
| wd_a | input | 18 | Write data, rising-edge beat (beats 0, 2) |
| wd_b | input | 18 | Write data, falling-edge beat (beats 1, 3) |
| bw_a_n | input | 2 | Byte enables for `wd_a`, active low |
| bw_b_n | input | 2 | Byte enables for `wd_b`, active low |
| rd_n | input | 1 | Read command, active low |
| rd_addr | input | AW | Read burst address |
| rd_valid | output | 1 | Read beats present on `rq_a`/`rq_b` |
| rq_a | output | 18 | Read data, beats 0 then 2 |
| rq_b | output | 18 | Read data, beats 1 then 3 |

## Verification
In a single cycle, the last beats of a write can enter the buffer while a read command samples the same address. A write can also complete and push the oldest entry into the array while a read forwards from the entries that remain. The bench provokes both cases by forking a write with a read started two cycles later, and by overlapping write bursts back to back with partial enables. The scoreboard takes its expected value when the read command is driven, so the read must return the data from before that write. A read issued later must return the new data. Resets after two and after three writes show whether the oldest entry reached the array at the right time.

// File: rtl/sram_b4_pkg.sv
package sram_b4_pkg;
    localparam int BEATS         = 4;
    localparam int BEATS_PER_CYC = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } burst_ph_e;
endpackage

// File: rtl/sram_b4_array.sv
module sram_b4_array #(
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                                    clk,
    input  logic                                    we,
    input  logic [AW-1:0]                           waddr,
    input  logic [BYTE_W*NBYTES*sram_b4_pkg::BEATS-1:0] wline,
    input  logic [NBYTES*sram_b4_pkg::BEATS-1:0]    wen,
    input  logic [AW-1:0]                           raddr,
    output logic [BYTE_W*NBYTES*sram_b4_pkg::BEATS-1:0] rline
);
    localparam int DEPTH = 2 ** AW;
    localparam int LANES = NBYTES * sram_b4_pkg::BEATS;

    // one storage lane per byte of the burst line
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wen[b]) begin
                lane_mem[waddr] <= wline[b*BYTE_W +: BYTE_W];
            end
        end

        assign rline[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/sram_b4_wcol.sv
module sram_b4_wcol
    import sram_b4_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_n,
    input  logic [AW-1:0]                        wr_addr,
    input  logic [BYTE_W*NBYTES-1:0]             wd_a,
    input  logic [BYTE_W*NBYTES-1:0]             wd_b,
    input  logic [NBYTES-1:0]                    bw_a_n,
    input  logic [NBYTES-1:0]                    bw_b_n,
    output logic                                 push,
    output logic [AW-1:0]                        push_addr,
    output logic [BYTE_W*NBYTES*BEATS-1:0]       push_line,
    output logic [NBYTES*BEATS-1:0]              push_en
);
    localparam int DW     = BYTE_W * NBYTES;
    localparam int HALF_W = DW * BEATS_PER_CYC;
    localparam int HALF_M = NBYTES * BEATS_PER_CYC;

    typedef struct packed {
        burst_ph_e         ph;
        logic [AW-1:0]     addr;
        logic [HALF_W-1:0] lo;
        logic [HALF_M-1:0] lo_en;
    } wcol_st_t;

    wcol_st_t s_d, s_q;
    logic     accept;

    always_comb begin
        s_d    = s_q;
        accept = !wr_n && (s_q.ph != PH_FIRST);
        case (s_q.ph)
            PH_FIRST: begin
                s_d.ph    = PH_SECOND;
                s_d.lo    = {wd_b, wd_a};
                s_d.lo_en = {~bw_b_n, ~bw_a_n};
            end
            default: s_d.ph = accept ? PH_FIRST : PH_IDLE;
        endcase
        if (accept) begin
            s_d.addr = wr_addr;
        end
        if (rst) begin
            s_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // the burst is complete at the edge that takes beats 2 and 3
    assign push      = (s_q.ph == PH_SECOND);
    assign push_addr = s_q.addr;
    assign push_line = {wd_b, wd_a, s_q.lo};
    assign push_en   = {~bw_b_n, ~bw_a_n, s_q.lo_en};

    assert_push_gap_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_n && s_q.ph == PH_IDLE) |=> (s_q.ph == PH_IDLE));
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_FIRST) |=> (s_q.ph == PH_SECOND));
endmodule

// File: rtl/sram_b4_wbuf.sv
module sram_b4_wbuf
    import sram_b4_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [AW-1:0]                  push_addr,
    input  logic [BYTE_W*NBYTES*BEATS-1:0] push_line,
    input  logic [NBYTES*BEATS-1:0]        push_en,
    input  logic [AW-1:0]                  look_addr,
    input  logic [BYTE_W*NBYTES*BEATS-1:0] arr_line,
    output logic [BYTE_W*NBYTES*BEATS-1:0] look_line,
    output logic                           cm_we,
    output logic [AW-1:0]                  cm_addr,
    output logic [BYTE_W*NBYTES*BEATS-1:0] cm_line,
    output logic [NBYTES*BEATS-1:0]        cm_en
);
    localparam int LW = BYTE_W * NBYTES * BEATS;
    localparam int MW = NBYTES * BEATS;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [LW-1:0] line;
        logic [MW-1:0] en;
    } ent_t;

    typedef struct packed {
        ent_t newer;
        ent_t older;
    } wbuf_st_t;

    wbuf_st_t s_d, s_q;
    logic     hit_new, hit_old;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.older          = s_q.newer;
            s_d.newer.v        = 1'b1;
            s_d.newer.addr     = push_addr;
            s_d.newer.line     = push_line;
            s_d.newer.en       = push_en;
        end
        if (rst) begin
            s_d.newer.v = 1'b0;
            s_d.older.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // the older entry leaves for the array when a new burst displaces it
    assign cm_we   = push && s_q.older.v && !rst;
    assign cm_addr = s_q.older.addr;
    assign cm_line = s_q.older.line;
    assign cm_en   = s_q.older.en;

    assign hit_new = s_q.newer.v && (s_q.newer.addr == look_addr);
    assign hit_old = s_q.older.v && (s_q.older.addr == look_addr);

    always_comb begin
        for (int b = 0; b < MW; b++) begin
            if (hit_new && s_q.newer.en[b]) begin
                look_line[b*BYTE_W +: BYTE_W] = s_q.newer.line[b*BYTE_W +: BYTE_W];
            end else if (hit_old && s_q.older.en[b]) begin
                look_line[b*BYTE_W +: BYTE_W] = s_q.older.line[b*BYTE_W +: BYTE_W];
            end else begin
                look_line[b*BYTE_W +: BYTE_W] = arr_line[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assert_older_needs_newer_R9: assert property (@(posedge clk) disable iff (rst)
        s_q.older.v |-> s_q.newer.v);
    assert_reset_empty_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!s_q.newer.v && !s_q.older.v));
endmodule

// File: rtl/sram_b4_rport.sv
module sram_b4_rport
    import sram_b4_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_n,
    input  logic [AW-1:0]                  rd_addr,
    input  logic [BYTE_W*NBYTES*BEATS-1:0] look_line,
    output logic [AW-1:0]                  look_addr,
    output logic                           rd_valid,
    output logic [BYTE_W*NBYTES-1:0]       rq_a,
    output logic [BYTE_W*NBYTES-1:0]       rq_b
);
    localparam int DW = BYTE_W * NBYTES;
    localparam int LW = DW * BEATS;

    typedef struct packed {
        burst_ph_e     ph;
        logic [LW-1:0] hold;
    } rport_st_t;

    rport_st_t s_d, s_q;
    logic      accept;

    assign look_addr = rd_addr;

    always_comb begin
        s_d    = s_q;
        accept = !rd_n && (s_q.ph != PH_FIRST);
        case (s_q.ph)
            PH_FIRST: s_d.ph = PH_SECOND;
            default:  s_d.ph = accept ? PH_FIRST : PH_IDLE;
        endcase
        if (accept) begin
            s_d.hold = look_line;
        end
        if (rst) begin
            s_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        rd_valid = (s_q.ph != PH_IDLE);
        case (s_q.ph)
            PH_FIRST: begin
                rq_a = s_q.hold[0*DW +: DW];
                rq_b = s_q.hold[1*DW +: DW];
            end
            PH_SECOND: begin
                rq_a = s_q.hold[2*DW +: DW];
                rq_b = s_q.hold[3*DW +: DW];
            end
            default: begin
                rq_a = '0;
                rq_b = '0;
            end
        endcase
    end

    assert_accept_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && s_q.ph != PH_FIRST) |=> rd_valid);
    assert_two_beats_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid);
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == PH_FIRST) |=> (s_q.ph == PH_SECOND));
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);
endmodule

// File: rtl/sram_b4_core.sv
module sram_b4_core
    import sram_b4_pkg::*;
#(
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_n,
    input  logic [AW-1:0]              wr_addr,
    input  logic [BYTE_W*NBYTES-1:0]   wd_a,
    input  logic [BYTE_W*NBYTES-1:0]   wd_b,
    input  logic [NBYTES-1:0]          bw_a_n,
    input  logic [NBYTES-1:0]          bw_b_n,
    input  logic                       rd_n,
    input  logic [AW-1:0]              rd_addr,
    output logic                       rd_valid,
    output logic [BYTE_W*NBYTES-1:0]   rq_a,
    output logic [BYTE_W*NBYTES-1:0]   rq_b
);
    localparam int LW = BYTE_W * NBYTES * BEATS;
    localparam int MW = NBYTES * BEATS;

    logic          wc_push;
    logic [AW-1:0] wc_addr;
    logic [LW-1:0] wc_line;
    logic [MW-1:0] wc_en;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [LW-1:0] arr_wline;
    logic [MW-1:0] arr_wen;
    logic [AW-1:0] look_addr;
    logic [LW-1:0] arr_rline;
    logic [LW-1:0] look_line;

    sram_b4_wcol #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wcol (
        .clk       (clk),
        .rst       (rst),
        .wr_n      (wr_n),
        .wr_addr   (wr_addr),
        .wd_a      (wd_a),
        .wd_b      (wd_b),
        .bw_a_n    (bw_a_n),
        .bw_b_n    (bw_b_n),
        .push      (wc_push),
        .push_addr (wc_addr),
        .push_line (wc_line),
        .push_en   (wc_en)
    );

    sram_b4_wbuf #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (wc_push),
        .push_addr (wc_addr),
        .push_line (wc_line),
        .push_en   (wc_en),
        .look_addr (look_addr),
        .arr_line  (arr_rline),
        .look_line (look_line),
        .cm_we     (arr_we),
        .cm_addr   (arr_waddr),
        .cm_line   (arr_wline),
        .cm_en     (arr_wen)
    );

    sram_b4_array #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wline (arr_wline),
        .wen   (arr_wen),
        .raddr (look_addr),
        .rline (arr_rline)
    );

    sram_b4_rport #(.AW(AW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_rport (
        .clk       (clk),
        .rst       (rst),
        .rd_n      (rd_n),
        .rd_addr   (rd_addr),
        .look_line (look_line),
        .look_addr (look_addr),
        .rd_valid  (rd_valid),
        .rq_a      (rq_a),
        .rq_b      (rq_b)
    );

    assert_commit_on_push_R9: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> wc_push);
endmodule

// File: tb/sram_b4_core_test.sv
module sram_b4_core_test;
    localparam int AW = 8;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int DW = BW * NB;
    localparam int LW = DW * 4;
    localparam int MW = NB * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wd_a = '0;
    logic [DW-1:0] wd_b = '0;
    logic [NB-1:0] bw_a_n = '1;
    logic [NB-1:0] bw_b_n = '1;
    logic          rd_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rq_a;
    logic [DW-1:0] rq_b;

    always #10 clk = ~clk;

    sram_b4_core #(.AW(AW), .BYTE_W(BW), .NBYTES(NB)) uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr),
        .wd_a(wd_a), .wd_b(wd_b), .bw_a_n(bw_a_n), .bw_b_n(bw_b_n),
        .rd_n(rd_n), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rq_a(rq_a), .rq_b(rq_b)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [LW-1:0] vis [256];
    logic [LW-1:0] com [256];

    typedef struct packed {
        logic [AW-1:0] a;
        logic [LW-1:0] line;
        logic [MW-1:0] en;
    } pend_t;
    pend_t pq[$];

    logic [2*DW-1:0] exp_q[$];
    string           tag_q[$];
    logic [2*DW-1:0] mon_exp;
    string           mon_tag;

    function automatic logic [LW-1:0] merge(input logic [LW-1:0] old,
                                            input logic [LW-1:0] nw,
                                            input logic [MW-1:0] en);
        logic [LW-1:0] r;
        r = old;
        for (int b = 0; b < MW; b++) begin
            if (en[b]) r[b*BW +: BW] = nw[b*BW +: BW];
        end
        return r;
    endfunction

    function automatic logic [LW-1:0] mk(input logic [7:0] a, input logic [7:0] s);
        logic [LW-1:0] r;
        for (int k = 0; k < 4; k++) begin
            r[k*DW +: DW] = {s, a, 2'(k)};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_done(input logic [AW-1:0] a, input logic [LW-1:0] line,
                              input logic [MW-1:0] en);
        pend_t p;
        pend_t o;
        vis[a] = merge(vis[a], line, en);
        p.a = a; p.line = line; p.en = en;
        pq.push_back(p);
        if (pq.size() > 2) begin
            o = pq.pop_front();
            com[o.a] = merge(com[o.a], o.line, o.en);
        end
    endtask

    // en: active-high byte mask, beat k byte j at bit 2k+j
    task automatic do_write(input logic [AW-1:0] a, input logic [LW-1:0] line,
                            input logic [MW-1:0] en);
        @(negedge clk);
        wr_n = 1'b0; wr_addr = a;
        @(negedge clk);
        wr_n = 1'b1;
        wd_a = line[0*DW +: DW]; wd_b = line[1*DW +: DW];
        bw_a_n = ~en[1:0]; bw_b_n = ~en[3:2];
        @(negedge clk);
        wd_a = line[2*DW +: DW]; wd_b = line[3*DW +: DW];
        bw_a_n = ~en[5:4]; bw_b_n = ~en[7:6];
        @(posedge clk);
        model_done(a, line, en);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rd_n = 1'b0; rd_addr = a;
        exp_q.push_back(vis[a][0 +: 2*DW]);   tag_q.push_back(tag);
        exp_q.push_back(vis[a][2*DW +: 2*DW]); tag_q.push_back(tag);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid low in reset", 36'(rd_valid), '0);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) vis[i] = com[i];
        pq.delete();
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid low after reset", 36'(rd_valid), '0);
    endtask

    // scoreboard monitor: pops expected pairs as beats appear
    always @(negedge clk) begin
        if (!finished && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected read beat", {rq_b, rq_a}, '0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check({rq_b, rq_a} === mon_exp, mon_tag, {rq_b, rq_a}, mon_exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            vis[i] = '0;
            com[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 reset state", 36'(rd_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 first cycle after reset", 36'(rd_valid), '0);

        // R2: full bursts to 0..15, then back-to-back reads (R3)
        for (int a = 0; a < 16; a++) do_write(8'(a), mk(8'(a), 8'h10), 8'hFF);
        for (int a = 0; a < 16; a++) do_read(8'(a), "R2 R3 full burst readback");

        // R4: partial byte write
        do_write(8'd3, mk(8'd3, 8'h44), 8'b1010_0101);
        do_read(8'd3, "R4 partial byte write");

        // R5: beat 2 aborted (its two enables high)
        do_write(8'd4, mk(8'd4, 8'h55), 8'b1100_1111);
        do_read(8'd4, "R5 aborted beat kept");

        // R6: lanes toggled while no write command
        @(negedge clk);
        wr_addr = 8'd5; wd_a = '1; wd_b = '1; bw_a_n = '0; bw_b_n = '0;
        repeat (3) @(negedge clk);
        do_read(8'd5, "R6 no write without command");

        // R8: two buffered entries on one address, newest wins per byte
        do_write(8'd6, mk(8'd6, 8'h61), 8'hFF);
        do_write(8'd6, mk(8'd6, 8'h62), 8'h5A);
        do_read(8'd6, "R8 merge of two buffered entries");
        do_write(8'd7, mk(8'd7, 8'h71), 8'h0F);
        do_read(8'd6, "R8 older entry after commit");
        do_read(8'd7, "R8 buffered partial over array");

        // R7: write command in the busy cycle is ignored
        @(negedge clk);
        wr_n = 1'b0; wr_addr = 8'd8;
        @(negedge clk);
        wr_n = 1'b0; wr_addr = 8'd9;
        wd_a = mk(8'd8, 8'h81)[0 +: DW]; wd_b = mk(8'd8, 8'h81)[DW +: DW];
        bw_a_n = '0; bw_b_n = '0;
        @(negedge clk);
        wr_n = 1'b1;
        wd_a = mk(8'd8, 8'h81)[2*DW +: DW]; wd_b = mk(8'd8, 8'h81)[3*DW +: DW];
        @(posedge clk);
        model_done(8'd8, mk(8'd8, 8'h81), 8'hFF);
        do_read(8'd9, "R7 busy-cycle write ignored");
        do_read(8'd8, "R7 first write kept");

        // R7: read command in the busy cycle is ignored
        @(negedge clk);
        rd_n = 1'b0; rd_addr = 8'd1;
        exp_q.push_back(vis[1][0 +: 2*DW]);    tag_q.push_back("R7 read busy cycle");
        exp_q.push_back(vis[1][2*DW +: 2*DW]); tag_q.push_back("R7 read busy cycle");
        @(negedge clk);
        rd_addr = 8'd2;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 ignored read gives no beats", 36'(rd_valid), '0);

        // R10: read at the edge of the last write beats sees old data
        fork
            do_write(8'd10, mk(8'd10, 8'hA1), 8'hFF);
            begin repeat (2) @(negedge clk); do_read(8'd10, "R10 same-edge read old"); end
        join
        do_read(8'd10, "R10 later read new");

        // R11: read and write issued at the same edge
        fork
            do_write(8'd11, mk(8'd11, 8'hB1), 8'hFF);
            do_read(8'd12, "R11 concurrent read");
        join
        do_read(8'd11, "R11 concurrent write landed");

        // R2 R8: overlapped bursts, newest partial on top
        fork
            do_write(8'd13, mk(8'd13, 8'hC1), 8'hFF);
            begin repeat (2) @(negedge clk); do_write(8'd14, mk(8'd14, 8'hC2), 8'hFF); end
            begin repeat (4) @(negedge clk); do_write(8'd13, mk(8'd13, 8'hC3), 8'h33); end
        join
        do_read(8'd13, "R8 overlapped newest wins");
        do_read(8'd14, "R2 overlapped burst");

        // R12: buffered writes lost on reset
        do_write(8'd2, mk(8'd2, 8'hD1), 8'hFF);
        do_reset();
        do_read(8'd2, "R12 buffered write dropped");
        do_read(8'd13, "R12 reset restores array");

        // R9: third write commits the first one
        do_write(8'd1, mk(8'd1, 8'hE1), 8'hFF);
        do_write(8'd2, mk(8'd2, 8'hE2), 8'hFF);
        do_write(8'd3, mk(8'd3, 8'hE3), 8'hFF);
        do_reset();
        do_read(8'd1, "R9 committed on third write");
        do_read(8'd2, "R9 second write still buffered");
        do_read(8'd3, "R9 third write still buffered");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 every read returned", 36'(exp_q.size()), '0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule